// File: doc/BRIEF.md
# Grouped four-bit pattern detector

This block watches a single serial data line and splits the incoming bits into back-to-back, non-overlapping frames of four bits each. Frame alignment starts with the first bit sampled after reset is released. On the clock cycle that carries the last bit of a frame, the detector raises its match output if the frame, read in arrival order, spells either `1010` or `0110`. It then returns to its start state, whatever the outcome, so each frame is judged on its own and no bits are shared between frames.

The detector is a Mealy machine. Its match output depends on the present state and on the bit being presented. The states use a fixed, hand-assigned three-bit code. Seven codes are reachable, and the eighth code (`001`) is treated as illegal. The state register is brought out as a port so that a surrounding checker or a test can observe frame progress. Reset is synchronous and active low.

Top module: `grp4_detect`

## Requirements
- R1: While `rst_n` is low, `match` is 0. After a rising clock edge with `rst_n` low, `state_q` is `000` (the start code).
- R2: Bits are consumed in non-overlapping frames of four. After the fourth bit of every frame, `state_q` is `000` again, whether or not the frame matched.
- R3: On the fourth bit of a frame, `match` is 1 exactly when the frame, first-arrived bit leftmost, is `1010` or `0110`.
- R4: On the first, second and third bit of a frame, `match` is 0.
- R5: After the first bit of a frame, `state_q` is `011` if that bit was 0 and `010` if it was 1.
- R6: After the second bit, `state_q` is `111` if the first two bits differ and `101` if they are equal.
- R7: After the third bit, `state_q` is `110` if the first three bits are `101` or `011`, and `100` otherwise.
- R8: The code `001` is never reached from reset. If it is ever present, it leads to `000` on the next clock and never raises `match`.
- R9: The 20-bit input stream `0010 0110 1100 1010 0011` yields the output stream `0000 0001 0000 0001 0000`.
- R10: A reset applied in the middle of a frame discards the partial frame. The next bit after release is treated as the first bit of a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Serial data bit, one per clock |
| match | output | 1 | Mealy output, high on the last bit of a matching frame |
| state_q | output | 3 | Present state code, exposed for observation |

## Verification
The assertions assume that `din` holds a defined 0 or 1 at every rising edge and that `rst_n` is low at the first edge, which puts the state register in a known code. The stimulus drives `din` and `rst_n` only on falling edges. It holds reset low from time zero and never leaves the data line undriven. Within that envelope the stimulus covers the reference stream, all sixteen frame values, a long pseudo-random stream and a reset that cuts a frame short.

// File: rtl/grp4_pkg.sv
// Package: grp4_pkg
// Shared state codes for the grouped four-bit detector. The code values are
// fixed by the design and are observed at the state_q port.
package grp4_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_START = 3'b000,
        ST_SPARE = 3'b001,
        ST_ONE   = 3'b010,
        ST_ZERO  = 3'b011,
        ST_DEAD3 = 3'b100,
        ST_DEAD2 = 3'b101,
        ST_LIVE3 = 3'b110,
        ST_LIVE2 = 3'b111
    } state_e;

endpackage

// File: rtl/grp4_next.sv
// Module: grp4_next
// Next-state logic of the detector. Live states mean the frame can still
// become a target pattern; dead states only count out the rest of the frame.
// Assumes: cur is a registered code; any code outside the seven reachable
// ones leads back to the start state.
module grp4_next
    import grp4_pkg::*;
(
    input  state_e cur,
    input  logic   din,
    output state_e nxt
);

    // Transition table of the seven-state frame machine.
    always_comb begin
        case (cur)
            ST_START: nxt = din ? ST_ONE   : ST_ZERO;
            ST_ZERO:  nxt = din ? ST_LIVE2 : ST_DEAD2;
            ST_ONE:   nxt = din ? ST_DEAD2 : ST_LIVE2;
            ST_DEAD2: nxt = ST_DEAD3;
            ST_LIVE2: nxt = din ? ST_LIVE3 : ST_DEAD3;
            ST_DEAD3: nxt = ST_START;
            ST_LIVE3: nxt = ST_START;
            default:  nxt = ST_START;
        endcase
    end

endmodule

// File: rtl/grp4_out.sv
// Module: grp4_out
// Mealy output decode. The output is high only when the last bit of a live
// frame is a zero. It is forced low while reset is held.
// Assumes: rst_n is the same synchronous reset as the state register.
module grp4_out
    import grp4_pkg::*;
(
    input  state_e cur,
    input  logic   din,
    input  logic   rst_n,
    output logic   match
);

    // Decode the single matching condition.
    always_comb begin
        match = rst_n && (cur == ST_LIVE3) && !din;
    end

endmodule

// File: rtl/grp4_detect.sv
// Module: grp4_detect
// Top of the grouped four-bit detector: state register, next-state logic and
// output decode. Frames of four bits are judged one at a time, and the
// machine restarts after every fourth bit.
// Assumes: din is defined at every rising edge; rst_n is low at the first edge.
module grp4_detect
    import grp4_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               din,
    output logic               match,
    output logic [STATE_W-1:0] state_q
);

    state_e cur;
    state_e nxt;

    grp4_next u_next (
        .cur (cur),
        .din (din),
        .nxt (nxt)
    );

    grp4_out u_out (
        .cur   (cur),
        .din   (din),
        .rst_n (rst_n),
        .match (match)
    );

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_START;
        else        cur <= nxt;
    end

    assign state_q = cur;

    AST_RST_START: assert property (@(posedge clk) !rst_n |=> cur == ST_START); // R1
    AST_RST_QUIET: assert property (@(posedge clk) !rst_n |-> !match); // R1
    AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n) (cur == ST_DEAD3 || cur == ST_LIVE3) |=> cur == ST_START); // R2
    AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n) match |=> cur == ST_START); // R3
    AST_NO_EARLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (cur == ST_START || cur == ST_ZERO || cur == ST_ONE) |-> !match); // R4
    AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cur == ST_START && !din) |=> cur == ST_ZERO); // R5
    AST_SECOND_DIFF: assert property (@(posedge clk) disable iff (!rst_n) (cur == ST_ZERO && din) |=> cur == ST_LIVE2); // R6
    AST_DEAD_STAYS: assert property (@(posedge clk) disable iff (!rst_n) cur == ST_DEAD2 |=> (cur == ST_DEAD3 && !match)); // R7
    AST_SPARE_EXIT: assert property (@(posedge clk) disable iff (!rst_n) cur == ST_SPARE |=> cur == ST_START); // R8
    AST_NO_SPARE: assert property (@(posedge clk) disable iff (!rst_n) cur != ST_SPARE); // R8

endmodule

// File: tb/tb_grp4_detect.sv
// Bench for grp4_detect: a behavioural reference model (bit position and
// frame prefix) compared against the ports on every bit.
module tb_grp4_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic       match;
    logic [2:0] state_q;

    int         checks = 0;
    int         errors = 0;
    int         pos = 0;
    logic [2:0] pre = 3'b000;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    grp4_detect dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .match   (match),
        .state_q (state_q)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_state(input int p, input logic [2:0] pr);
        case (p)
            0:       return 3'b000;
            1:       return pr[0] ? 3'b010 : 3'b011;
            2:       return (pr[1] ^ pr[0]) ? 3'b111 : 3'b101;
            default: return (pr == 3'b101 || pr == 3'b011) ? 3'b110 : 3'b100;
        endcase
    endfunction

    // Present one bit, compare state and output, then advance the model.
    task automatic send(input bit b, output bit m);
        logic [2:0] es;
        bit em;
        @(negedge clk);
        din = b;
        #1;
        es = exp_state(pos, pre);
        em = (pos == 3) && !b && (pre == 3'b101 || pre == 3'b011);
        case (pos)
            0: chk(state_q == es, "R2", state_q, es);
            1: chk(state_q == es, "R5", state_q, es);
            2: chk(state_q == es, "R6", state_q, es);
            default: chk(state_q == es, "R7", state_q, es);
        endcase
        if (pos == 3) chk(match == em, "R3", match, em);
        else          chk(match == 1'b0, "R4", match, 0);
        chk(state_q != 3'b001 && !(state_q == 3'b001 && match), "R8", state_q, 0);
        m = match;
        @(posedge clk);
        if (pos == 3) begin
            pos = 0;
            pre = 3'b000;
        end else begin
            pre = {pre[1:0], b};
            pos++;
        end
    endtask

    // Apply reset for one edge; release it before the next falling edge.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din = 1'b1;
        #1;
        chk(match == 1'b0, "R1", match, 0);
        @(posedge clk);
        #1;
        chk(state_q == 3'b000, "R1", state_q, 0);
        rst_n = 1'b1;
        pos = 0;
        pre = 3'b000;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit m;
        logic [19:0] stim;
        logic [19:0] got;
        logic [19:0] want;
        do_reset();

        // R9: reference stream
        stim = 20'b0010_0110_1100_1010_0011;
        want = 20'b0000_0001_0000_0001_0000;
        for (int i = 19; i >= 0; i--) begin
            send(stim[i], m);
            got[i] = m;
        end
        chk(got == want, "R9", got, want);

        // R3: every frame value
        for (int v = 0; v < 16; v++) begin
            for (int k = 3; k >= 0; k--) send(v[k], m);
        end

        // R10: reset in the middle of a frame, then a full target frame
        send(1'b0, m);
        send(1'b1, m);
        send(1'b1, m);
        do_reset();
        send(1'b1, m);
        send(1'b0, m);
        send(1'b1, m);
        send(1'b0, m);
        chk(m == 1'b1, "R10", m, 1);

        // R2: long pseudo-random stream
        for (int i = 0; i < 400; i++) send(1'($urandom_range(0, 1)), m);

        do_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule